// File: doc/BRIEF.md
# Stream Record Access Unit

This block holds one stream in a private on-chip record buffer and serves its records one at a time. The buffer is filled through a dedicated write port. A consumer then issues record requests, and the block turns each request into a buffer address according to the selected access mode. Sequential and conditional modes walk the stream in order. Gather mode takes an arbitrary index carried with the request. Indexed mode adds an offset taken from the request to a fixed reference position and rejects offsets that fall outside a configured window. Strided and bit-reversed modes produce derived streams from a running position counter.

Each record leaves through a valid/ready output. The buffer read takes one cycle. The record register stays unchanged for as long as the consumer stalls, and new requests are held off while it is full. Loading the configuration returns the position to zero. For the walking modes, a finish flag marks the point where the position has covered the configured length.

Top module: `stream_access_unit`

## Requirements
- R1: After reset, rec_valid, done and ofs_err are low and req_ready is high.
- R2: In mode code 0 (sequential), each accepted request returns the record at base+position, and the position then increases by one.
- R3: In mode code 1 (conditional), an accepted request with req_cond low returns no record and leaves the position unchanged. With req_cond high it behaves as in R2.
- R4: In mode code 2 (gather), an accepted request returns the record at base+req_arg, and the position is unchanged.
- R5: In mode code 3 (indexed), the request offset req_arg must satisfy win_lo <= req_arg <= win_hi. The record at base+position+req_arg is returned, and the position is unchanged.
- R6: An indexed request whose offset is outside the window returns no record, and ofs_err is high for exactly the cycle after it is accepted.
- R7: In mode code 4 (strided), the record at base+position*stride is returned, and the position then increases by one.
- R8: In mode code 5 (bit-reversed), with cfg_len a power of two 2^k, the record at base+reverse(position[k-1:0]) is returned, and the position then increases by one.
- R9: A record is valid on rec_valid in the cycle right after its request is accepted. All buffer address arithmetic wraps modulo the buffer depth.
- R10: While rec_valid is high and rec_ready is low, rec_data stays unchanged and req_ready is low.
- R11: In modes 0, 4 and 5, done rises once the position reaches cfg_len. While done is high, req_ready is low. A cfg_load pulse clears done and resets the position to 0.
- R12: A write on the fill port stores fill_data at fill_addr, and a later read returns that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Buffer write enable |
| fill_addr | input | ADDR_W | Buffer write address |
| fill_data | input | DATA_W | Buffer write data |
| cfg_load | input | 1 | Restart: position to 0, clear done |
| cfg_mode | input | 3 | Access mode code |
| cfg_base | input | ADDR_W | Stream base address |
| cfg_len | input | ADDR_W+1 | Stream length in records |
| cfg_stride | input | ADDR_W | Stride for strided mode |
| cfg_win_lo | input | ADDR_W | Lowest legal indexed offset |
| cfg_win_hi | input | ADDR_W | Highest legal indexed offset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_arg | input | ADDR_W | Gather index or indexed offset |
| req_cond | input | 1 | Condition code for conditional mode |
| rec_valid | output | 1 | Output record valid |
| rec_ready | input | 1 | Consumer takes the record |
| rec_data | output | DATA_W | Output record |
| done | output | 1 | Walking mode has covered the length |
| ofs_err | output | 1 | Indexed offset fell outside the window |

## Verification
The bench aims at the address corner cases of each mode. The bit-reversed order over a length of eight exposes a reversal done over the full address width, because that design would jump far outside the stream. Indexed offsets at both window edges, and one just past the upper edge, catch an off-by-one bound: such a design would either reject a legal offset or return a record where an error is due. Conditional requests with a false code catch a design that advances anyway: it would skip the next record. A stalled consumer checks that the held record does not get overwritten. Running a sequential stream to its end checks that done rises after exactly the configured count and that further requests are refused.

// File: rtl/sau_pkg.sv
package sau_pkg;
   typedef enum logic [2:0] {
      SAU_SEQ    = 3'd0,
      SAU_COND   = 3'd1,
      SAU_GATHER = 3'd2,
      SAU_INDEX  = 3'd3,
      SAU_STRIDE = 3'd4,
      SAU_BITREV = 3'd5
   } sau_mode_e;
endpackage

// File: rtl/sau_ram.sv
module sau_ram #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/sau_addr_gen.sv
module sau_addr_gen
   import sau_pkg::*;
#(
   parameter int ADDR_W = 6,
   localparam int LEN_W = ADDR_W + 1,
   localparam int LG_W  = $clog2(ADDR_W + 1)
) (
   input  sau_mode_e         mode,
   input  logic [ADDR_W-1:0] base,
   input  logic [LEN_W-1:0]  len,
   input  logic [ADDR_W-1:0] stride,
   input  logic [LEN_W-1:0]  pos,
   input  logic [ADDR_W-1:0] arg,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] pos_lo;
   logic [ADDR_W-1:0] rev_full;
   logic [ADDR_W-1:0] rev_pos;
   logic [ADDR_W-1:0] prod;
   logic [LG_W-1:0]   lg;
   logic [LG_W-1:0]   sh;

   assign pos_lo = pos[ADDR_W-1:0];

   // full-width mirror of the position, one wire per bit
   for (genvar j = 0; j < ADDR_W; j++) begin : g_rev
      assign rev_full[j] = pos_lo[ADDR_W-1-j];
   end

   // log2 of the length: index of its highest set bit
   always_comb begin
      lg = '0;
      for (int i = 0; i < LEN_W; i++) begin
         if (len[i]) lg = LG_W'(i);
      end
   end

   always_comb begin
      sh = LG_W'(ADDR_W) - lg;
      if (lg > LG_W'(ADDR_W)) sh = '0;
   end

   assign rev_pos = rev_full >> sh;

   always_comb begin
      prod = ADDR_W'(pos_lo * stride);
   end

   always_comb begin
      unique case (mode)
         SAU_GATHER: addr = base + arg;
         SAU_INDEX:  addr = base + pos_lo + arg;
         SAU_STRIDE: addr = base + prod;
         SAU_BITREV: addr = base + rev_pos;
         default:    addr = base + pos_lo;
      endcase
   end
endmodule

// File: rtl/stream_access_unit.sv
module stream_access_unit
   import sau_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int LEN_W  = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_en,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              cfg_load,
   input  logic [2:0]        cfg_mode,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic [ADDR_W-1:0] cfg_stride,
   input  logic [ADDR_W-1:0] cfg_win_lo,
   input  logic [ADDR_W-1:0] cfg_win_hi,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_arg,
   input  logic              req_cond,
   output logic              rec_valid,
   input  logic              rec_ready,
   output logic [DATA_W-1:0] rec_data,
   output logic              done,
   output logic              ofs_err
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   sau_mode_e         mode;
   logic [LEN_W-1:0]  pos;
   logic [LEN_W-1:0]  pos_nx;
   logic [ADDR_W-1:0] rd_addr;
   logic              accept, in_win, bad, skip, issue, advance, walker;

   assign mode    = sau_mode_e'(cfg_mode);
   assign accept  = req_valid && req_ready;
   assign in_win  = (req_arg >= cfg_win_lo) && (req_arg <= cfg_win_hi);
   assign bad     = accept && (mode == SAU_INDEX) && !in_win;
   assign skip    = accept && (mode == SAU_COND) && !req_cond;
   assign issue   = accept && !bad && !skip;
   assign walker  = (mode == SAU_SEQ) || (mode == SAU_STRIDE) || (mode == SAU_BITREV);
   assign advance = accept && (walker || ((mode == SAU_COND) && req_cond));
   assign pos_nx  = pos + LEN_W'(1);

   assign req_ready = (!rec_valid || rec_ready) && !done;

   sau_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
      .mode   (mode),
      .base   (cfg_base),
      .len    (cfg_len),
      .stride (cfg_stride),
      .pos    (pos),
      .arg    (req_arg),
      .addr   (rd_addr)
   );

   sau_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
      .clk   (clk),
      .we    (fill_en),
      .waddr (fill_addr),
      .wdata (fill_data),
      .re    (issue),
      .raddr (rd_addr),
      .rdata (rec_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos       <= '0;
         done      <= 1'b0;
         rec_valid <= 1'b0;
         ofs_err   <= 1'b0;
      end else begin
         ofs_err <= bad;
         if (issue)          rec_valid <= 1'b1;
         else if (rec_ready) rec_valid <= 1'b0;
         if (cfg_load) begin
            pos  <= '0;
            done <= 1'b0;
         end else if (advance) begin
            pos <= pos_nx;
            if (walker && pos_nx == cfg_len) done <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sau_checker.sv
module sau_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        cfg_mode,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_cond,
   input logic              rec_valid,
   input logic              rec_ready,
   input logic [DATA_W-1:0] rec_data,
   input logic              done,
   input logic              ofs_err
);
   // R10
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data)));

   // R10
   stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && !rec_ready) |-> !req_ready);

   // R11
   done_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_ready);

   // R9
   rec_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rec_valid) |-> $past(req_valid && req_ready));

   // R3
   cond_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && cfg_mode == 3'd1 && !req_cond) |=> !rec_valid);

   // R6
   err_no_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_err |-> !rec_valid);

   // R6
   err_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_err |-> $past(req_valid && req_ready && cfg_mode == 3'd3));
endmodule

bind stream_access_unit sau_checker #(.DATA_W(DATA_W)) u_sau_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_mode  (cfg_mode),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_cond  (req_cond),
   .rec_valid (rec_valid),
   .rec_ready (rec_ready),
   .rec_data  (rec_data),
   .done      (done),
   .ofs_err   (ofs_err)
);

// File: tb/stream_access_unit_bench.sv
module stream_access_unit_bench;
   localparam int DATA_W = 32;
   localparam int DEPTH  = 64;
   localparam int ADDR_W = 6;
   localparam int LEN_W  = 7;

   logic              clk = 0;
   logic              rst_n = 0;
   logic              fill_en = 0;
   logic [ADDR_W-1:0] fill_addr = '0;
   logic [DATA_W-1:0] fill_data = '0;
   logic              cfg_load = 0;
   logic [2:0]        cfg_mode = '0;
   logic [ADDR_W-1:0] cfg_base = '0;
   logic [LEN_W-1:0]  cfg_len = '0;
   logic [ADDR_W-1:0] cfg_stride = '0;
   logic [ADDR_W-1:0] cfg_win_lo = '0;
   logic [ADDR_W-1:0] cfg_win_hi = '0;
   logic              req_valid = 0;
   logic              req_ready;
   logic [ADDR_W-1:0] req_arg = '0;
   logic              req_cond = 0;
   logic              rec_valid;
   logic              rec_ready = 1;
   logic [DATA_W-1:0] rec_data;
   logic              done;
   logic              ofs_err;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   stream_access_unit #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stream_access_unit (.*);

   function automatic logic [DATA_W-1:0] memval(input int a);
      return 32'hC0DE0000 + DATA_W'((a % DEPTH) * 5);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                      input logic [DATA_W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic setcfg(input logic [2:0] m, input int base, input int len,
                         input int stride, input int lo, input int hi);
      @(negedge clk);
      cfg_mode = m; cfg_base = ADDR_W'(base); cfg_len = LEN_W'(len);
      cfg_stride = ADDR_W'(stride); cfg_win_lo = ADDR_W'(lo); cfg_win_hi = ADDR_W'(hi);
      cfg_load = 1;
      @(negedge clk);
      cfg_load = 0;
   endtask

   task automatic rd(input int arg, input bit cond, output bit got,
                     output logic [DATA_W-1:0] d, output bit e);
      @(negedge clk);
      req_valid = 1; req_arg = ADDR_W'(arg); req_cond = cond;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 0;
      got = rec_valid; d = rec_data; e = ofs_err;
   endtask

   task automatic expect_rec(input int addr, input string tag, input int arg, input bit cond);
      bit got, e; logic [DATA_W-1:0] d;
      rd(arg, cond, got, d, e);
      chk(got, {tag, " valid"}, DATA_W'(got), 1);
      chk(d == memval(addr), {tag, " data"}, d, memval(addr));
   endtask

   task automatic t_fill();   // R12
      for (int a = 0; a < DEPTH; a++) begin
         @(negedge clk);
         fill_en = 1; fill_addr = ADDR_W'(a); fill_data = memval(a);
      end
      @(negedge clk);
      fill_en = 0;
      setcfg(3'd2, 0, 64, 0, 0, 0);
      expect_rec(63, "R12 fill", 63, 0);
   endtask

   task automatic t_reset();   // R1
      chk(!rec_valid, "R1 rec_valid", DATA_W'(rec_valid), 0);
      chk(!done, "R1 done", DATA_W'(done), 0);
      chk(!ofs_err, "R1 ofs_err", DATA_W'(ofs_err), 0);
      chk(req_ready, "R1 req_ready", DATA_W'(req_ready), 1);
   endtask

   task automatic t_seq();   // R2 R11 R9
      setcfg(3'd0, 8, 4, 0, 0, 0);
      for (int i = 0; i < 4; i++) expect_rec(8 + i, "R2 seq", 0, 0);
      chk(done, "R11 done set", DATA_W'(done), 1);
      chk(!req_ready, "R11 ready low", DATA_W'(req_ready), 0);
      setcfg(3'd0, 8, 4, 0, 0, 0);
      chk(!done, "R11 load clears", DATA_W'(done), 0);
      expect_rec(8, "R11 restart", 0, 0);
   endtask

   task automatic t_cond();   // R3
      bit got, e; logic [DATA_W-1:0] d;
      setcfg(3'd1, 20, 8, 0, 0, 0);
      expect_rec(20, "R3 cond true", 0, 1);
      rd(0, 0, got, d, e);
      chk(!got, "R3 cond false no rec", DATA_W'(got), 0);
      expect_rec(21, "R3 no advance", 0, 1);
   endtask

   task automatic t_gather();   // R4
      setcfg(3'd2, 10, 8, 0, 0, 0);
      expect_rec(15, "R4 gather", 5, 0);
      expect_rec(50, "R4 gather", 40, 0);
      expect_rec(10 + 60, "R4 gather wrap", 60, 0);
   endtask

   task automatic t_index();   // R5 R6
      bit got, e; logic [DATA_W-1:0] d;
      setcfg(3'd3, 30, 16, 0, 0, 8);
      expect_rec(30, "R5 idx 0", 0, 0);
      expect_rec(32, "R5 idx 2", 2, 0);
      expect_rec(34, "R5 idx 4", 4, 0);
      expect_rec(38, "R5 idx 8 edge", 8, 0);
      rd(9, 0, got, d, e);
      chk(!got, "R6 no record", DATA_W'(got), 0);
      chk(e, "R6 err flag", DATA_W'(e), 1);
      @(negedge clk);
      chk(!ofs_err, "R6 err one cycle", DATA_W'(ofs_err), 0);
      setcfg(3'd3, 30, 16, 0, 2, 8);
      rd(1, 0, got, d, e);
      chk(e && !got, "R6 below lo", DATA_W'(e), 1);
      expect_rec(32, "R5 lo edge", 2, 0);
   endtask

   task automatic t_stride();   // R7
      setcfg(3'd4, 0, 4, 3, 0, 0);
      for (int i = 0; i < 4; i++) expect_rec(3 * i, "R7 stride", 0, 0);
      chk(done, "R11 stride done", DATA_W'(done), 1);
   endtask

   task automatic t_bitrev();   // R8
      int rv[8] = '{0, 4, 2, 6, 1, 5, 3, 7};
      setcfg(3'd5, 16, 8, 0, 0, 0);
      for (int i = 0; i < 8; i++) expect_rec(16 + rv[i], "R8 bitrev", 0, 0);
      chk(done, "R11 bitrev done", DATA_W'(done), 1);
   endtask

   task automatic t_stall();   // R10
      bit got, e; logic [DATA_W-1:0] d;
      setcfg(3'd2, 0, 8, 0, 0, 0);
      rec_ready = 0;
      rd(7, 0, got, d, e);
      chk(got && d == memval(7), "R10 first", d, memval(7));
      repeat (3) @(negedge clk);
      chk(rec_valid && rec_data == memval(7), "R10 held", rec_data, memval(7));
      chk(!req_ready, "R10 ready low", DATA_W'(req_ready), 0);
      rec_ready = 1;
      @(negedge clk);
      chk(!rec_valid, "R10 drained", DATA_W'(rec_valid), 0);
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_fill();
      t_seq();
      t_cond();
      t_gather();
      t_index();
      t_stride();
      t_bitrev();
      t_stall();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule